// File: doc/BRIEF.md
# UART Receive Queue with Trigger and Character Timeout

This block sits between a UART's receive shift register and the CPU. Each completed byte is offered on a valid/ready input stream and stored in a first-in first-out queue of 16 entries. The CPU takes bytes from the queue through a valid/ready output stream. Raising `out_ready` while `out_valid` is high is one read.

A data interrupt is raised while the fill level is at or above a programmable trigger level. A byte that arrives when the queue is full is discarded and sets a sticky overrun flag. Some bytes at the end of a burst may not reach the trigger level. To keep them from staying in the queue unnoticed, a timeout interrupt is raised after four character times with no read and no arrival.

Back-pressure rules: `in_ready` is low exactly when the queue holds 16 bytes. The shift register cannot stall, so an offered byte is never held back. If the queue is full and no read happens in the same cycle, the byte is dropped. If a read happens in that same cycle, the byte is stored. On the output side, `out_data` always shows the oldest byte while `out_valid` is high, and a byte is consumed on each clock edge where both `out_valid` and `out_ready` are high.

Top module: `uart_rx_queue`

## Requirements
- R1: The queue holds at most 16 bytes. `fill_count` reports the number held, and `in_ready` is low exactly when `fill_count` is 16.
- R2: Bytes leave in arrival order. `out_valid` is high whenever `fill_count` is non-zero, and `out_data` shows the oldest byte.
- R3: `trig_sel` selects the trigger level: 0 means 1 byte, 1 means 4, 2 means 8 and 3 means 14. `trig_irq` is high while `rx_irq_en` is high and `fill_count` is at or above the selected level.
- R4: `trig_irq` falls in the cycle after a read brings `fill_count` below the trigger level.
- R5: A byte offered while the queue is full, with no read in the same cycle, is discarded and `fill_count` stays at 16. A byte offered while full together with a read is stored.
- R6: `overrun` rises the cycle after a discarded byte. It stays high until a cycle with `status_rd` high clears it. A new discard in the same cycle as `status_rd` wins, and the flag stays set.
- R7: With at least one byte held, `tout_irq` rises (with `rx_irq_en` high) the cycle after the 4×TICKS_PER_CHAR-th `char_tick` pulse that has no read and no arrival since the last read or arrival.
- R8: Any read or any offered byte clears the timeout condition and restarts its tick count. The tick count is held at zero while the queue is empty, so `tout_irq` is never high when `fill_count` is 0.
- R9: With `rx_irq_en` low, both `trig_irq` and `tout_irq` are low. The pending timeout condition is kept and shows again once the enable returns.
- R10: After reset the queue is empty, `in_ready` is high, and `out_valid`, `overrun`, `trig_irq` and `tout_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received byte is offered |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Queue has room (low when full) |
| out_valid | output | 1 | Queue holds at least one byte |
| out_ready | input | 1 | CPU read strobe |
| out_data | output | 8 | Oldest byte in the queue |
| trig_sel | input | 2 | Trigger level code |
| rx_irq_en | input | 1 | Receive interrupt enable |
| char_tick | input | 1 | One pulse per tick; TICKS_PER_CHAR ticks form one character time |
| status_rd | input | 1 | Status read strobe, clears overrun |
| fill_count | output | 5 | Bytes currently held |
| overrun | output | 1 | Sticky overrun flag |
| trig_irq | output | 1 | Trigger-level data interrupt |
| tout_irq | output | 1 | Character timeout interrupt |

## Verification
The bench builds the block with DEPTH 16 and TICKS_PER_CHAR 2, so one timeout window is only eight tick pulses. That makes it cheap to test one tick short of the window, the exact expiry and a restart by a mid-window arrival. The full depth keeps every trigger code reachable, and the bench checks each code one byte below and exactly at its level. It also fills the queue to test the drop, the stored byte when a write and a read happen together, and the sticky flag.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE     = 2'd0,
    TRIG_QUARTER = 2'd1,
    TRIG_HALF    = 2'd2,
    TRIG_NEAR    = 2'd3
  } trig_sel_e;

  // Fill level at which the data interrupt asserts, scaled to the depth.
  function automatic int unsigned trig_level(input logic [1:0] sel,
                                             input int unsigned depth);
    case (trig_sel_e'(sel))
      TRIG_ONE:     return 1;
      TRIG_QUARTER: return depth / 4;
      TRIG_HALF:    return depth / 2;
      default:      return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rxq_storage.sv
module rxq_storage #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty,
  output logic              drop
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = pop_req && !empty;
  assign push_ok = push_req && (!full || pop_ok);
  assign drop    = push_req && full && !pop_ok;
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [1:0]    sel,
  input  logic [CW-1:0] count,
  input  logic          enable,
  output logic          irq
);
  logic [CW-1:0] level;
  assign level = CW'(trig_level(sel, DEPTH));
  assign irq   = enable && (count >= level);
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int LIMIT = 64,
  localparam int TW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic restart,
  input  logic tick,
  output logic expired
);
  logic [TW-1:0] ticks;

  assign expired = (ticks == TW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ticks <= '0;
    else if (hold || restart) ticks <= '0;
    else if (tick && !expired) ticks <= ticks + 1'b1;
  end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DATA_W         = 8,
  parameter int DEPTH          = 16,
  parameter int TICKS_PER_CHAR = 16,
  parameter int TIMEOUT_CHARS  = 4,
  localparam int CW            = $clog2(DEPTH + 1),
  localparam int LIMIT         = TICKS_PER_CHAR * TIMEOUT_CHARS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic [1:0]        trig_sel,
  input  logic              rx_irq_en,
  input  logic              char_tick,
  input  logic              status_rd,
  output logic [CW-1:0]     fill_count,
  output logic              overrun,
  output logic              trig_irq,
  output logic              tout_irq
);
  logic full, empty, drop, expired, pop;

  assign pop = out_valid && out_ready;

  rxq_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_req(in_valid), .wr_data(in_data),
    .pop_req(out_ready), .rd_data(out_data),
    .count(fill_count), .full(full), .empty(empty), .drop(drop)
  );

  rxq_trigger #(.DEPTH(DEPTH)) u_trig (
    .sel(trig_sel), .count(fill_count), .enable(rx_irq_en), .irq(trig_irq)
  );

  rxq_timeout #(.LIMIT(LIMIT)) u_tout (
    .clk(clk), .rst_n(rst_n),
    .hold(empty), .restart(in_valid || pop), .tick(char_tick),
    .expired(expired)
  );

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign tout_irq  = rx_irq_en && expired && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overrun <= 1'b0;
    else if (drop)      overrun <= 1'b1;
    else if (status_rd) overrun <= 1'b0;
  end
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          rx_irq_en,
  input logic [CW-1:0] fill_count,
  input logic          overrun,
  input logic          trig_irq,
  input logic          tout_irq
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH)); // R1
  AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == CW'(DEPTH)) |-> !in_ready); // R1
  AST_FULL_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill_count == CW'(DEPTH) && !out_ready) |=> (fill_count == CW'(DEPTH))); // R5
  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill_count == CW'(DEPTH) && !out_ready) |=> overrun); // R6
  AST_TOUT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == '0) |-> !tout_irq); // R8
  AST_TOUT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid || (out_valid && out_ready)) |=> !tout_irq); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq_en |-> (!trig_irq && !tout_irq)); // R9
endmodule

bind uart_rx_queue rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .rx_irq_en(rx_irq_en),
  .fill_count(fill_count), .overrun(overrun), .trig_irq(trig_irq),
  .tout_irq(tout_irq)
);

// File: tb/sim_uart_rx_queue.sv
module sim_uart_rx_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int TPC   = 2;
  localparam int WIN   = 4 * TPC;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, rx_irq_en = 1, char_tick = 0, status_rd = 0;
  logic [7:0] in_data = 0;
  logic [1:0] trig_sel = 0;
  logic in_ready, out_valid, overrun, trig_irq, tout_irq;
  logic [7:0] out_data;
  logic [4:0] fill_count;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_queue #(.DATA_W(8), .DEPTH(DEPTH), .TICKS_PER_CHAR(TPC), .TIMEOUT_CHARS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .trig_sel(trig_sel), .rx_irq_en(rx_irq_en),
    .char_tick(char_tick), .status_rd(status_rd), .fill_count(fill_count),
    .overrun(overrun), .trig_irq(trig_irq), .tout_irq(tout_irq)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic [4:0] n;
    logic       irq;
  } vec_t;

  // trigger code, bytes pushed from empty, expected trig_irq (R3)
  localparam vec_t VECS [8] = '{
    '{2'd0, 5'd0,  1'b0}, '{2'd0, 5'd1,  1'b1},
    '{2'd1, 5'd3,  1'b0}, '{2'd1, 5'd4,  1'b1},
    '{2'd2, 5'd7,  1'b0}, '{2'd2, 5'd8,  1'b1},
    '{2'd3, 5'd13, 1'b0}, '{2'd3, 5'd14, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); in_valid = 1; in_data = b;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic pop_expect(input string tag, input logic [7:0] b);
    chk(tag, out_data, b);
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0;
  endtask

  task automatic drain();
    while (out_valid) begin
      @(negedge clk); out_ready = 1;
      @(negedge clk); out_ready = 0;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); char_tick = 1;
      @(negedge clk); char_tick = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 fill", fill_count, 0);
    chk("R10 in_ready", in_ready, 1);
    chk("R10 out_valid", out_valid, 0);
    chk("R10 overrun", overrun, 0);
    chk("R10 trig_irq", trig_irq, 0);
    chk("R10 tout_irq", tout_irq, 0);

    // R3 vector walk
    foreach (VECS[k]) begin
      trig_sel = VECS[k].sel;
      for (int i = 0; i < int'(VECS[k].n); i++) push(8'(i));
      chk("R3 trig level", trig_irq, VECS[k].irq);
      chk("R1 fill count", fill_count, VECS[k].n);
      drain();
    end

    // R4 drop below level
    trig_sel = 2'd3;
    for (int i = 0; i < 14; i++) push(8'(i));
    chk("R4 at level", trig_irq, 1);
    pop_expect("R2 oldest", 8'd0);
    chk("R4 below level", trig_irq, 0);
    drain();
    trig_sel = 2'd0;

    // R2 ordering
    for (int i = 0; i < 5; i++) push(8'h11 + 8'(i));
    chk("R2 out_valid", out_valid, 1);
    for (int i = 0; i < 5; i++) pop_expect("R2 order", 8'h11 + 8'(i));
    chk("R2 empty", out_valid, 0);

    // R1 / R5 / R6 full and overrun
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i));
    chk("R1 full count", fill_count, 16);
    chk("R1 in_ready low", in_ready, 0);
    push(8'hEE);
    chk("R5 dropped count", fill_count, 16);
    chk("R6 overrun set", overrun, 1);
    repeat (3) @(negedge clk);
    chk("R6 sticky", overrun, 1);
    @(negedge clk); status_rd = 1;
    @(negedge clk); status_rd = 0;
    chk("R6 cleared", overrun, 0);
    // R5 write with simultaneous read when full
    @(negedge clk); in_valid = 1; in_data = 8'h77; out_ready = 1;
    @(negedge clk); in_valid = 0; out_ready = 0;
    chk("R5 stored with read", fill_count, 16);
    chk("R5 no overrun", overrun, 0);
    for (int i = 1; i < 16; i++) pop_expect("R5 order", 8'h40 + 8'(i));
    pop_expect("R5 stored byte", 8'h77);
    // R6 set wins over clear
    for (int i = 0; i < 16; i++) push(8'(i));
    @(negedge clk); in_valid = 1; status_rd = 1;
    @(negedge clk); in_valid = 0; status_rd = 0;
    chk("R6 set wins", overrun, 1);
    @(negedge clk); status_rd = 1;
    @(negedge clk); status_rd = 0;
    drain();

    // R7 timeout window
    push(8'hA1);
    ticks(WIN - 1);
    chk("R7 one tick short", tout_irq, 0);
    ticks(1);
    chk("R7 expiry", tout_irq, 1);
    // R9 enable gating
    rx_irq_en = 0;
    @(negedge clk);
    chk("R9 tout masked", tout_irq, 0);
    chk("R9 trig masked", trig_irq, 0);
    rx_irq_en = 1;
    @(negedge clk);
    chk("R9 tout restored", tout_irq, 1);
    // R8 read clears
    pop_expect("R8 byte", 8'hA1);
    chk("R8 cleared by read", tout_irq, 0);
    // R8 arrival restarts
    push(8'hB1);
    ticks(WIN);
    chk("R7 second expiry", tout_irq, 1);
    push(8'hB2);
    chk("R8 cleared by arrival", tout_irq, 0);
    ticks(WIN - 1);
    chk("R8 restarted window", tout_irq, 0);
    ticks(1);
    chk("R8 new expiry", tout_irq, 1);
    drain();
    // R8 held while empty
    ticks(WIN + 4);
    push(8'hC1);
    ticks(WIN - 1);
    chk("R8 held at zero when empty", tout_irq, 0);
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule